// File: doc/BRIEF.md
# Static Memory Strobe Timing Sequencer

This block drives the control strobes for a single bank of asynchronous static memory. It has three active-low strobes. The output enable frames the whole access, and the read and write strobes pulse inside it. A requester raises a request together with a direction bit and a 32-bit timing word. The sequencer then runs three phases, setup, access and hold, and counts system clock cycles for each one. When it has finished it releases the output enable and pulses a done flag for one cycle.

Each phase length is unpacked from a field of the timing word. The two 3-bit setup fields use a wrapped code in which 0 stands for eight cycles. A 6-bit write access field of 0 has no legal meaning. The block runs it as one cycle and sets a sticky error flag. A read access always lasts a fixed number of cycles set by a parameter, and so does the read hold. The timing word is captured only when a request is accepted.

Top module: `smc_strobe_seq`

## Requirements
- R1: After reset, oe_n, rd_n and wr_n are high, and done and cfg_err are low.
- R2: For a read, oe_n is low for N cycles before rd_n falls. N is bits 18:16 of the timing word, except that the code 0 means N = 8.
- R3: For a write, oe_n is low for N cycles before wr_n falls. N is bits 2:0 of the timing word, except that the code 0 means N = 8.
- R4: For a write, wr_n stays low for the number of cycles in bits 13:8 of the timing word, which may be 1 to 63.
- R5: After wr_n rises, oe_n stays low for the number of cycles in bits 6:4 of the timing word. This may be 0 to 7, and 0 means oe_n rises together with wr_n.
- R6: For a read, rd_n stays low for RD_ACCESS cycles (default 4). oe_n then stays low for a further RD_HOLD cycles (default 1).
- R7: A write whose bits 13:8 are 0 holds wr_n low for exactly one cycle and sets cfg_err. Once set, cfg_err stays high until reset.
- R8: done is high for exactly one cycle. That cycle is the first one in which oe_n is high again after an access.
- R9: A request that arrives while an access is in progress is ignored. A change to the timing word after a request has been accepted does not affect that access.
- R10: rd_n and wr_n are never low at the same time. Neither of them is low while oe_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request; accepted only when the sequencer is idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| timing | input | 32 | Packed timing word, sampled when the request is accepted |
| oe_n | output | 1 | Active-low output enable that frames the access |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Sticky flag set by an illegal write access code |

## Verification
Every output is a register. A request accepted at clock edge k therefore pulls oe_n low by edge k, and the strobe falls at edge k+S. The strobe rises at edge k+S+A, and oe_n rises and done goes high at edge k+S+A+H. done drops again one edge later. The bench samples at falling edges. It counts how many samples fall into each phase and compares those counts with S, A and H as worked out from the timing word. In the first sample after oe_n rises it expects done high, and in the sample after that it expects done low and oe_n still high. On the first sample of every access phase it drives a stray request with a new timing word. Both the stray request and the new word must leave the measured phase lengths unchanged.

// File: rtl/smc_strobe_pkg.sv
package smc_strobe_pkg;

  // Width of every phase counter and of each decoded duration.
  localparam int PH_CNT_W = 6;

  // Field layout of the packed timing word.
  localparam int RD_SU_LSB  = 16;
  localparam int WR_ACC_LSB = 8;
  localparam int WR_HLD_LSB = 4;
  localparam int WR_SU_LSB  = 0;
  localparam int SU_W       = 3;
  localparam int ACC_W      = 6;
  localparam int HLD_W      = 3;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  typedef struct packed {
    logic [PH_CNT_W-1:0] setup;
    logic [PH_CNT_W-1:0] access;
    logic [PH_CNT_W-1:0] hold;
  } phase_times_t;

endpackage

// File: rtl/smc_strobe_decode.sv
module smc_strobe_decode
  import smc_strobe_pkg::*;
#(
  parameter int CFG_W     = 32,
  parameter int RD_ACCESS = 4,
  parameter int RD_HOLD   = 1
) (
  input  logic [CFG_W-1:0] cfg,
  input  logic             is_write,
  output phase_times_t     times,
  output logic             bad_access
);

  localparam logic [PH_CNT_W-1:0] RD_ACC_C = PH_CNT_W'(RD_ACCESS);
  localparam logic [PH_CNT_W-1:0] RD_HLD_C = PH_CNT_W'(RD_HOLD);

  logic [SU_W-1:0]  rd_su_f;
  logic [SU_W-1:0]  wr_su_f;
  logic [ACC_W-1:0] wr_acc_f;
  logic [HLD_W-1:0] wr_hld_f;

  assign rd_su_f  = cfg[RD_SU_LSB  +: SU_W];
  assign wr_su_f  = cfg[WR_SU_LSB  +: SU_W];
  assign wr_acc_f = cfg[WR_ACC_LSB +: ACC_W];
  assign wr_hld_f = cfg[WR_HLD_LSB +: HLD_W];

  // Wrapped setup code: zero stands for the longest setup.
  function automatic logic [PH_CNT_W-1:0] su_len(input logic [SU_W-1:0] f);
    if (f == '0) su_len = PH_CNT_W'(1 << SU_W);
    else         su_len = PH_CNT_W'(f);
  endfunction

  always_comb begin
    bad_access = 1'b0;
    if (is_write) begin
      times.setup = su_len(wr_su_f);
      times.hold  = PH_CNT_W'(wr_hld_f);
      if (wr_acc_f == '0) begin
        times.access = PH_CNT_W'(1);
        bad_access   = 1'b1;
      end else begin
        times.access = PH_CNT_W'(wr_acc_f);
      end
    end else begin
      times.setup  = su_len(rd_su_f);
      times.access = RD_ACC_C;
      times.hold   = RD_HLD_C;
    end
  end

endmodule

// File: rtl/smc_strobe_counter.sv
module smc_strobe_counter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (load)     cnt_q <= load_val;
    else if (!zero)    cnt_q <= cnt_q - W'(1);
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/smc_strobe_seq.sv
module smc_strobe_seq
  import smc_strobe_pkg::*;
#(
  parameter int CFG_W     = 32,
  parameter int RD_ACCESS = 4,
  parameter int RD_HOLD   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             req_write,
  input  logic [CFG_W-1:0] timing,
  output logic             oe_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic             done,
  output logic             cfg_err
);

  localparam logic [PH_CNT_W-1:0] ONE = PH_CNT_W'(1);

  phase_e       phase_q;
  phase_times_t live_t;
  phase_times_t held_t;
  logic         live_bad;
  logic         write_q;
  logic         accept;
  logic         cnt_load;
  logic [PH_CNT_W-1:0] cnt_val;
  logic         cnt_zero;

  smc_strobe_decode #(
    .CFG_W     (CFG_W),
    .RD_ACCESS (RD_ACCESS),
    .RD_HOLD   (RD_HOLD)
  ) i_decode (
    .cfg        (timing),
    .is_write   (req_write),
    .times      (live_t),
    .bad_access (live_bad)
  );

  smc_strobe_counter #(
    .W (PH_CNT_W)
  ) i_counter (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  assign accept = req && (phase_q == PH_IDLE);

  // Counter reload at each phase boundary; loaded value is length minus one.
  always_comb begin
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (phase_q)
      PH_IDLE: if (req) begin
        cnt_load = 1'b1;
        cnt_val  = live_t.setup - ONE;
      end
      PH_SETUP: if (cnt_zero) begin
        cnt_load = 1'b1;
        cnt_val  = held_t.access - ONE;
      end
      PH_ACCESS: if (cnt_zero && held_t.hold != '0) begin
        cnt_load = 1'b1;
        cnt_val  = held_t.hold - ONE;
      end
      PH_HOLD: ;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      held_t  <= '0;
      write_q <= 1'b0;
      oe_n    <= 1'b1;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      done    <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (accept) begin
          held_t  <= live_t;
          write_q <= req_write;
          oe_n    <= 1'b0;
          phase_q <= PH_SETUP;
          if (req_write && live_bad) cfg_err <= 1'b1;
        end
        PH_SETUP: if (cnt_zero) begin
          rd_n    <= write_q;
          wr_n    <= !write_q;
          phase_q <= PH_ACCESS;
        end
        PH_ACCESS: if (cnt_zero) begin
          rd_n <= 1'b1;
          wr_n <= 1'b1;
          if (held_t.hold == '0) begin
            oe_n    <= 1'b1;
            done    <= 1'b1;
            phase_q <= PH_IDLE;
          end else begin
            phase_q <= PH_HOLD;
          end
        end
        PH_HOLD: if (cnt_zero) begin
          oe_n    <= 1'b1;
          done    <= 1'b1;
          phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/smc_strobe_chk.sv
module smc_strobe_chk (
  input logic clk,
  input logic rst,
  input logic oe_n,
  input logic rd_n,
  input logic wr_n,
  input logic done,
  input logic cfg_err
);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  // R10
  strobe_framed_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> !oe_n);

  // R2
  rd_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_n) |-> $past(!oe_n));

  // R3
  wr_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_n) |-> $past(!oe_n));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_place_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $rose(oe_n));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);

endmodule

bind smc_strobe_seq smc_strobe_chk i_chk (
  .clk     (clk),
  .rst     (rst),
  .oe_n    (oe_n),
  .rd_n    (rd_n),
  .wr_n    (wr_n),
  .done    (done),
  .cfg_err (cfg_err)
);

// File: tb/test_smc_strobe_seq.sv
module test_smc_strobe_seq;

  localparam int RD_ACC = 4;
  localparam int RD_HLD = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] timing = '0;
  logic        oe_n, rd_n, wr_n, done, cfg_err;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  smc_strobe_seq i_smc_strobe_seq (
    .clk(clk), .rst(rst), .req(req), .req_write(req_write), .timing(timing),
    .oe_n(oe_n), .rd_n(rd_n), .wr_n(wr_n), .done(done), .cfg_err(cfg_err)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_su(input logic [31:0] c, input bit wr);
    int f = wr ? int'(c[2:0]) : int'(c[18:16]);
    return (f == 0) ? 8 : f;
  endfunction

  function automatic int exp_ac(input logic [31:0] c, input bit wr);
    if (!wr) return RD_ACC;
    return (c[13:8] == 0) ? 1 : int'(c[13:8]);
  endfunction

  function automatic int exp_ho(input logic [31:0] c, input bit wr);
    return wr ? int'(c[6:4]) : RD_HLD;
  endfunction

  function automatic logic [31:0] mk(input int rsu, input int wacc, input int whld, input int wsu);
    logic [31:0] c = $urandom;
    c[18:16] = 3'(rsu);
    c[13:8]  = 6'(wacc);
    c[6:4]   = 3'(whld);
    c[2:0]   = 3'(wsu);
    return c;
  endfunction

  task automatic txn(input bit wr, input logic [31:0] c);
    int su = 0, ac = 0, ho = 0, guard = 0;
    bit poked = 0, bad_other = 0;
    string sutag = wr ? "R3 setup" : "R2 setup";
    string actag = wr ? "R4 access" : "R6 access";
    string hotag = wr ? "R5 hold" : "R6 hold";
    @(negedge clk);
    req = 1'b1; req_write = wr; timing = c;
    @(negedge clk);
    timing = $urandom;          // R9: late change must not matter
    forever begin
      req = 1'b0;
      if (oe_n || guard > 300) break;
      if (!(wr ? rd_n : wr_n)) bad_other = 1;
      if (!(wr ? wr_n : rd_n)) begin
        ac++;
        if (!poked) begin       // R9: stray request during access
          req = 1'b1; req_write = !wr; timing = $urandom; poked = 1;
        end
      end else if (ac == 0) su++;
      else ho++;
      @(negedge clk);
      guard++;
    end
    check(sutag, su, exp_su(c, wr));
    check(actag, ac, exp_ac(c, wr));
    check(hotag, ho, exp_ho(c, wr));
    check("R10 other strobe idle", int'(bad_other), 0);
    check("R8 done high", int'(done), 1);
    @(negedge clk);
    check("R8 done low", int'(done), 0);
    check("R9 no stray start", int'(oe_n), 1);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0123));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check("R1 oe_n", int'(oe_n), 1);
    check("R1 rd_n", int'(rd_n), 1);
    check("R1 wr_n", int'(wr_n), 1);
    check("R1 done", int'(done), 0);
    check("R1 cfg_err", int'(cfg_err), 0);

    txn(1'b1, mk(3, 63, 0, 0));   // R3 zero code = 8, R4 max, R5 zero hold
    txn(1'b1, mk(0, 1, 7, 1));    // R4 min, R5 max hold
    txn(1'b0, mk(0, 0, 0, 5));    // R2 zero code = 8
    txn(1'b0, mk(1, 9, 2, 0));    // R2 min
    txn(1'b0, mk(5, 0, 0, 0));    // R2 mid
    check("R7 no error yet", int'(cfg_err), 0);
    txn(1'b1, mk(2, 0, 3, 4));    // R7 illegal access code
    check("R7 error set", int'(cfg_err), 1);

    for (int i = 0; i < 40; i++) begin
      bit wr = 1'($urandom);
      logic [31:0] c = $urandom;
      txn(wr, c);
    end
    check("R7 error sticky", int'(cfg_err), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule